// File: doc/BRIEF.md
# Condition Code Evaluator

This combinational unit reduces a 4-bit condition selector and a 5-bit status flag vector to one "condition holds" bit. The flags are zero, sign, carry, overflow and a sticky saturation flag. A conditional branch uses the bit to decide whether it is taken. A set-on-condition instruction uses the same bit, widened to a full register word that reads 1 or 0.

The signed comparisons are formed from sign XOR overflow. One selector value tests the saturation flag instead of any arithmetic flag.

A registered copy of the result is also provided for pipelined consumers. The copy is loaded only on cycles that carry a valid input, and an output strobe marks it one cycle later.

Top module: `cc_eval`

## Requirements
- R1: `flags_i` is ordered {sat, ov, cy, s, z}: z is bit 0, s bit 1, cy bit 2, ov bit 3 and sat bit 4. For selectors 0 to 7, `cond_o` is, in order: ov, cy, z, cy|z, s, 1, s^ov, (s^ov)|z.
- R2: Selectors 8 to 12 give the inverse of selectors 0 to 4: !ov, !cy, !z, !(cy|z), !s.
- R3: Selector 13 gives the saturation flag (bit 4) and ignores every other flag.
- R4: Selector 14 gives !(s^ov) (signed greater or equal). Selector 15 gives !((s^ov)|z) (signed greater than).
- R5: Selector 5 is true for all 32 flag combinations. No selector other than 13 depends on the saturation flag.
- R6: `setf_o` is a DATA_W-bit word equal to 1 when `cond_o` is 1 and equal to 0 otherwise. All bits above bit 0 are always zero.
- R7: When `valid_i` is high at a rising clock edge, `cond_q_o` takes that cycle's `cond_o` value and `valid_o` is high for the following cycle. When `valid_i` is low, `valid_o` goes low after the edge.
- R8: An active-low asynchronous reset clears `cond_q_o` and `valid_o` at once.
- R9: `cond_q_o` keeps its value across edges where `valid_i` is low, even when the selector and flags change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the registered copy |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies the selector and flags for capture |
| code_i | input | 4 | Condition selector |
| flags_i | input | 5 | Status flags {sat, ov, cy, s, z} |
| cond_o | output | 1 | Combinational condition result |
| setf_o | output | DATA_W (32) | Result widened to a register word |
| valid_o | output | 1 | Strobe for the registered result |
| cond_q_o | output | 1 | Registered condition result |

## Verification
The combinational path has no state, so a wrong flag term or a wrong inversion shows on `cond_o` and `setf_o` in the same cycle. It appears only for the selector and flag patterns that reach that term, which is why every selector is applied with all 32 flag combinations. A fault in the output register shows one cycle after a valid input, as a wrong `cond_q_o` or a wrong strobe. It can also show as a value that changes during cycles without a valid input. Reset is checked both before the first capture and in the middle of a run.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CODE_W  = 4;
  localparam int FLAG_W  = 5;
  localparam int N_CODE  = 1 << CODE_W;
  localparam int N_BASE  = N_CODE / 2;

  // flag bit positions inside flags_i
  localparam int F_Z   = 0;
  localparam int F_S   = 1;
  localparam int F_CY  = 2;
  localparam int F_OV  = 3;
  localparam int F_SAT = 4;

  // selector values with special handling
  localparam logic [CODE_W-1:0] SEL_ALWAYS = 4'd5;
  localparam logic [CODE_W-1:0] SEL_SAT    = 4'd13;

  typedef struct packed {
    logic sat;
    logic ov;
    logic cy;
    logic s;
    logic z;
  } flags_t;
endpackage

// File: rtl/cc_flag_terms.sv
module cc_flag_terms
  import cc_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  output logic [N_BASE-1:0] base_o,
  output logic              sat_o
);
  flags_t f;
  logic   lt;

  assign f  = flags_t'(flags_i);
  assign lt = f.s ^ f.ov;  // signed less-than

  always_comb begin
    base_o    = '0;
    base_o[0] = f.ov;
    base_o[1] = f.cy;
    base_o[2] = f.z;
    base_o[3] = f.cy | f.z;
    base_o[4] = f.s;
    base_o[5] = 1'b1;
    base_o[6] = lt;
    base_o[7] = lt | f.z;
  end

  assign sat_o = f.sat;
endmodule

// File: rtl/cc_select.sv
module cc_select
  import cc_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic [N_BASE-1:0] base_i,
  input  logic              sat_i,
  output logic              cond_o
);
  logic [N_CODE-1:0] table_w;

  // upper half negates lower half, except the saturation slot
  for (genvar i = 0; i < N_CODE; i++) begin : g_entry
    if (i == int'(SEL_SAT)) begin : g_sat
      assign table_w[i] = sat_i;
    end else if (i >= N_BASE) begin : g_neg
      assign table_w[i] = ~base_i[i-N_BASE];
    end else begin : g_pos
      assign table_w[i] = base_i[i];
    end
  end

  assign cond_o = table_w[code_i];
endmodule

// File: rtl/cc_out_reg.sv
module cc_out_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic cond_i,
  output logic valid_o,
  output logic cond_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      cond_q_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) cond_q_o <= cond_i;
    end
  end
endmodule

// File: rtl/cc_eval.sv
module cc_eval
  import cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              cond_o,
  output logic [DATA_W-1:0] setf_o,
  output logic              valid_o,
  output logic              cond_q_o
);
  logic [N_BASE-1:0] base_w;
  logic              sat_w;

  cc_flag_terms u_terms (
    .flags_i (flags_i),
    .base_o  (base_w),
    .sat_o   (sat_w)
  );

  cc_select u_sel (
    .code_i (code_i),
    .base_i (base_w),
    .sat_i  (sat_w),
    .cond_o (cond_o)
  );

  assign setf_o = {{(DATA_W-1){1'b0}}, cond_o};

  cc_out_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .cond_i   (cond_o),
    .valid_o  (valid_o),
    .cond_q_o (cond_q_o)
  );
endmodule

// File: rtl/cc_eval_chk.sv
module cc_eval_chk
  import cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [CODE_W-1:0] code_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              cond_o,
  input logic [DATA_W-1:0] setf_o,
  input logic              valid_o,
  input logic              cond_q_o
);
  p_always_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == SEL_ALWAYS) |-> cond_o);

  p_sat_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == SEL_SAT) |-> (cond_o == flags_i[F_SAT]));

  p_setf_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setf_o[DATA_W-1:1] == '0) && (setf_o[0] == cond_o));

  p_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (valid_o && (cond_q_o == $past(cond_o))));

  p_strobe_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cond_q_o));
endmodule

bind cc_eval cc_eval_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .code_i   (code_i),
  .flags_i  (flags_i),
  .cond_o   (cond_o),
  .setf_o   (setf_o),
  .valid_o  (valid_o),
  .cond_q_o (cond_q_o)
);

// File: tb/cc_eval_test.sv
module cc_eval_test;
  localparam int DATA_W = 32;
  localparam int WD_CYC = 200000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b1;
  logic              valid_i = 1'b0;
  logic [3:0]        code_i = '0;
  logic [4:0]        flags_i = '0;
  logic              cond_o;
  logic [DATA_W-1:0] setf_o;
  logic              valid_o;
  logic              cond_q_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;  // 4 ns period

  cc_eval #(.DATA_W(DATA_W)) uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .code_i   (code_i),
    .flags_i  (flags_i),
    .cond_o   (cond_o),
    .setf_o   (setf_o),
    .valid_o  (valid_o),
    .cond_q_o (cond_q_o)
  );

  // flags {sat, ov, cy, s, z}
  function automatic bit ref_cond(input logic [3:0] c, input logic [4:0] f);
    bit z, s, cy, ov, sat;
    z = f[0]; s = f[1]; cy = f[2]; ov = f[3]; sat = f[4];
    case (c)
      4'd0:    return ov;
      4'd1:    return cy;
      4'd2:    return z;
      4'd3:    return cy | z;
      4'd4:    return s;
      4'd5:    return 1'b1;
      4'd6:    return s ^ ov;
      4'd7:    return (s ^ ov) | z;
      4'd8:    return !ov;
      4'd9:    return !cy;
      4'd10:   return !z;
      4'd11:   return !(cy | z);
      4'd12:   return !s;
      4'd13:   return sat;
      4'd14:   return !(s ^ ov);
      default: return !((s ^ ov) | z);
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c == 4'd5) return "R5";
    if (c == 4'd13) return "R3";
    if (c >= 4'd14) return "R4";
    if (c >= 4'd8) return "R2";
    return "R1";
  endfunction

  task automatic chk(input string req, input logic [DATA_W-1:0] got,
                     input logic [DATA_W-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h code=%0d flags=%b t=%0t",
               req, got, exp, code_i, flags_i, $time);
    end
  endtask

  task automatic t_reset_state;
    @(negedge clk_i);
    chk("R8", valid_o, 0);
    chk("R8", cond_q_o, 0);
    rst_ni = 1'b1;
  endtask

  // all 16 selectors against all 32 flag patterns
  task automatic t_sweep;
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        code_i  = 4'(c);
        flags_i = 5'(f);
        #1;
        chk(req_of(4'(c)), DATA_W'(cond_o), DATA_W'(ref_cond(4'(c), 5'(f))));
        chk("R6", setf_o, DATA_W'(ref_cond(4'(c), 5'(f))));
      end
    end
  endtask

  // sat must not move any selector except 13
  task automatic t_sat_isolation;
    for (int c = 0; c < 16; c++) begin
      if (c != 13) begin
        for (int f = 0; f < 16; f++) begin
          logic a;
          code_i = 4'(c); flags_i = {1'b0, 4'(f)}; #1; a = cond_o;
          flags_i = {1'b1, 4'(f)}; #1;
          chk("R5", DATA_W'(cond_o), DATA_W'(a));
        end
      end
    end
  endtask

  task automatic t_pipeline;
    for (int k = 0; k < 40; k++) begin
      logic [3:0] c;
      logic [4:0] f;
      c = 4'((k * 7 + 3) % 16);
      f = 5'((k * 13 + 5) % 32);
      @(negedge clk_i);
      valid_i = 1'b1; code_i = c; flags_i = f;
      @(negedge clk_i);
      chk("R7", DATA_W'(valid_o), 1);
      chk("R7", DATA_W'(cond_q_o), DATA_W'(ref_cond(c, f)));
      valid_i = 1'b0;
    end
  endtask

  task automatic t_hold;
    logic held;
    @(negedge clk_i);
    valid_i = 1'b1; code_i = 4'd5; flags_i = '0;
    @(negedge clk_i);
    valid_i = 1'b0; code_i = 4'd13; flags_i = '0;  // comb result 0
    held = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      chk("R7", DATA_W'(valid_o), 0);
      chk("R9", DATA_W'(cond_q_o), DATA_W'(held));
      code_i = 4'(k + 8);
    end
    @(negedge clk_i);
    valid_i = 1'b1; code_i = 4'd2; flags_i = 5'b00000;  // z clear -> 0
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R7", DATA_W'(cond_q_o), 0);
    for (int k = 0; k < 3; k++) begin
      code_i = 4'd5;
      @(negedge clk_i);
      chk("R9", DATA_W'(cond_q_o), 0);
    end
  endtask

  task automatic t_mid_reset;
    @(negedge clk_i);
    valid_i = 1'b1; code_i = 4'd5;
    @(negedge clk_i);
    chk("R7", DATA_W'(cond_q_o), 1);
    #0.5 rst_ni = 1'b0;
    #0.5;
    chk("R8", DATA_W'(valid_o), 0);
    chk("R8", DATA_W'(cond_q_o), 0);
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    t_reset_state;
    t_sweep;
    t_sat_isolation;
    t_pipeline;
    t_hold;
    t_mid_reset;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule